// File: doc/BRIEF.md
# Exception Priority and Vector Unit

This unit sits beside a processor core's pipeline control and decides which of several simultaneous exception requests the core takes. Seven request lines arrive in parallel: hardware reset request, data abort, fast interrupt, normal interrupt, prefetch abort, software trap and undefined instruction. The unit holds the core's status word: a 3-bit mode code and two interrupt mask flags. It masks the two interrupt lines with those flags and picks one winner by a fixed priority.

For the winner it registers a vector address, switches the mode and updates the mask flags. In the same cycle it pulses strobes that carry the old status word and the return address to the banked storage of the new mode. That banked storage lies outside the unit. The unit then waits for the core to acknowledge the vector fetch before it looks at requests again.

A return input loads the status word from a value supplied by the core, which reads it from the banked copy. A flag write input changes the two mask flags, but only outside user mode.

Top module: `exc_vector_unit`

## Requirements
- R1: Among eligible requests the winner follows this order, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software trap. When undefined instruction and software trap are both asserted, undefined instruction wins.
- R2: The vector address is VEC_BASE plus an offset that depends on the winner: reset 0x00, undefined 0x04, software trap 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R3: On entry the mode field becomes the winner's mode. Mode codes: user 0, fast 1, normal-interrupt 2, supervisor 3, abort 4, undefined 5. Reset and software trap enter supervisor. Both aborts enter abort mode. Undefined enters undefined mode.
- R4: On entry save_stat_we and save_link_we pulse together. save_stat_val carries the status word as it was before entry, laid out as {mode[4:2], norm_mask[1], fast_mask[0]}. save_link_val carries ret_addr as sampled with the request.
- R5: Every entry sets the normal-interrupt mask (status bit 1) to 1.
- R6: The fast-interrupt mask (status bit 0) is set on entry only for fast interrupt and reset. All other entries leave it unchanged.
- R7: A normal-interrupt request is eligible only while bit 1 is 0, and a fast-interrupt request only while bit 0 is 0. Reset is never masked.
- R8: A return pulse with no entry in that cycle loads the whole status word from ret_status at the next clock edge.
- R9: A flag write loads bit 1 from flag_wr_i and bit 0 from flag_wr_f when the mode is not user. In user mode the write is ignored and the status word is unchanged.
- R10: take is registered: it is high for exactly one cycle, at the edge after the cycle in which the request was sampled.
- R11: After take, all requests, returns and flag writes are ignored until vec_ack is seen. Once vec_ack is seen, evaluation resumes from the following cycle.
- R12: If an eligible request meets a return or a flag write in the same cycle, the entry happens and the return or write is dropped.
- R13: After synchronous reset (rst high) the status word is supervisor with both masks set, and take is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fast | input | 1 | Fast interrupt request |
| req_norm | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_trap | input | 1 | Software trap request |
| req_undef | input | 1 | Undefined instruction request |
| ret_addr | input | AW | Return address offered with the requests |
| vec_ack | input | 1 | Core has fetched the vector |
| exc_ret | input | 1 | Return from handler |
| ret_status | input | 5 | Status word to restore on return |
| flag_wr | input | 1 | Mask flag write request |
| flag_wr_i | input | 1 | New normal-interrupt mask value |
| flag_wr_f | input | 1 | New fast-interrupt mask value |
| take | output | 1 | One-cycle exception taken strobe |
| vec_addr | output | AW | Vector address of taken exception |
| status_word | output | 5 | Current {mode, norm_mask, fast_mask} |
| save_stat_we | output | 1 | Strobe: store old status in banked copy |
| save_stat_val | output | 5 | Old status word |
| save_link_we | output | 1 | Strobe: store return address in banked copy |
| save_link_val | output | AW | Return address to bank |

## Verification
Two kinds of collision can land in the same cycle. An exception entry can coincide with a return, or it can coincide with a privileged flag write. The bench provokes each case by pulsing a request together with exc_ret, or with flag_wr, on the same clock edge. It then judges the saved status value and the status word that results: both must show the entry alone, with the return or the write lost. A second kind of overlap is new requests arriving while an acknowledge is pending. These are judged by counting take pulses, which must not rise until vec_ack has been given.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    M_USR  = 3'd0,
    M_FAST = 3'd1,
    M_NORM = 3'd2,
    M_SUP  = 3'd3,
    M_ABT  = 3'd4,
    M_UND  = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    X_NONE, X_RESET, X_DABT, X_FAST, X_NORM, X_PABT, X_UNDEF, X_TRAP
  } exc_e;

  localparam int STW = 5;
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_pkg::*;
(
  input  logic req_reset,
  input  logic req_dabt,
  input  logic req_fast,
  input  logic req_norm,
  input  logic req_pabt,
  input  logic req_trap,
  input  logic req_undef,
  input  logic mask_norm,
  input  logic mask_fast,
  output exc_e winner
);
  // Lowest priority first, each later test overrides.
  always_comb begin
    winner = X_NONE;
    if (req_trap)               winner = X_TRAP;
    if (req_undef)              winner = X_UNDEF;
    if (req_pabt)               winner = X_PABT;
    if (req_norm && !mask_norm) winner = X_NORM;
    if (req_fast && !mask_fast) winner = X_FAST;
    if (req_dabt)               winner = X_DABT;
    if (req_reset)              winner = X_RESET;
  end
endmodule

// File: rtl/exc_vec_map.sv
module exc_vec_map
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  exc_e          kind,
  output logic [AW-1:0] vec,
  output mode_e         mode,
  output logic          sets_fast
);
  logic [4:0] offs;

  always_comb begin
    offs      = 5'h00;
    mode      = M_SUP;
    sets_fast = 1'b0;
    unique case (kind)
      X_RESET: begin offs = 5'h00; mode = M_SUP;  sets_fast = 1'b1; end
      X_UNDEF: begin offs = 5'h04; mode = M_UND;  end
      X_TRAP:  begin offs = 5'h08; mode = M_SUP;  end
      X_PABT:  begin offs = 5'h0C; mode = M_ABT;  end
      X_DABT:  begin offs = 5'h10; mode = M_ABT;  end
      X_NORM:  begin offs = 5'h18; mode = M_NORM; end
      X_FAST:  begin offs = 5'h1C; mode = M_FAST; sets_fast = 1'b1; end
      default: begin offs = 5'h00; mode = M_SUP;  end
    endcase
  end

  assign vec = VEC_BASE + AW'(offs);
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_reset,
  input  logic           req_dabt,
  input  logic           req_fast,
  input  logic           req_norm,
  input  logic           req_pabt,
  input  logic           req_trap,
  input  logic           req_undef,
  input  logic [AW-1:0]  ret_addr,
  input  logic           vec_ack,
  input  logic           exc_ret,
  input  logic [STW-1:0] ret_status,
  input  logic           flag_wr,
  input  logic           flag_wr_i,
  input  logic           flag_wr_f,
  output logic           take,
  output logic [AW-1:0]  vec_addr,
  output logic [STW-1:0] status_word,
  output logic           save_stat_we,
  output logic [STW-1:0] save_stat_val,
  output logic           save_link_we,
  output logic [AW-1:0]  save_link_val
);
  localparam logic [AW-1:0] VEC_FAST = VEC_BASE + AW'(28);
  localparam logic [AW-1:0] VEC_NORM = VEC_BASE + AW'(24);

  mode_e          mode_q;
  logic           mnorm_q, mfast_q, busy_q, take_q, init_q;
  logic [AW-1:0]  vec_q, link_q;
  logic [STW-1:0] sv_q;

  exc_e           win;
  logic [AW-1:0]  vec_n;
  mode_e          mode_n;
  logic           set_f;

  exc_prio_sel u_sel (
    .req_reset (req_reset), .req_dabt (req_dabt), .req_fast (req_fast),
    .req_norm  (req_norm),  .req_pabt (req_pabt), .req_trap (req_trap),
    .req_undef (req_undef), .mask_norm(mnorm_q),  .mask_fast(mfast_q),
    .winner    (win)
  );

  exc_vec_map #(.AW(AW), .VEC_BASE(VEC_BASE)) u_map (
    .kind(win), .vec(vec_n), .mode(mode_n), .sets_fast(set_f)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_SUP;
      mnorm_q <= 1'b1;
      mfast_q <= 1'b1;
      busy_q  <= 1'b0;
      take_q  <= 1'b0;
      init_q  <= 1'b0;
      vec_q   <= '0;
      link_q  <= '0;
      sv_q    <= '0;
    end else begin
      init_q <= 1'b1;
      take_q <= 1'b0;
      if (busy_q) begin
        if (vec_ack) busy_q <= 1'b0;
      end else if (win != X_NONE) begin
        take_q  <= 1'b1;
        busy_q  <= 1'b1;
        vec_q   <= vec_n;
        sv_q    <= {mode_q, mnorm_q, mfast_q};
        link_q  <= ret_addr;
        mode_q  <= mode_n;
        mnorm_q <= 1'b1;
        if (set_f) mfast_q <= 1'b1;
      end else if (exc_ret) begin
        mode_q  <= mode_e'(ret_status[4:2]);
        mnorm_q <= ret_status[1];
        mfast_q <= ret_status[0];
      end else if (flag_wr && mode_q != M_USR) begin
        mnorm_q <= flag_wr_i;
        mfast_q <= flag_wr_f;
      end
    end
  end

  assign take          = take_q;
  assign vec_addr      = vec_q;
  assign status_word   = {mode_q, mnorm_q, mfast_q};
  assign save_stat_we  = take_q;
  assign save_stat_val = sv_q;
  assign save_link_we  = take_q;
  assign save_link_val = link_q;

  // R10
  take_one_cycle_chk: assert property (@(posedge clk) disable iff (rst || !init_q)
    take |=> !take);

  // R5
  entry_masks_norm_chk: assert property (@(posedge clk) disable iff (rst || !init_q)
    take |-> status_word[1]);

  // R4
  saved_status_chk: assert property (@(posedge clk) disable iff (rst || !init_q)
    take |-> save_stat_val == $past(status_word));

  // R1
  reset_wins_chk: assert property (@(posedge clk) disable iff (rst || !init_q)
    (take && $past(req_reset)) |-> vec_addr == VEC_BASE);

  // R7
  fast_masked_chk: assert property (@(posedge clk) disable iff (rst || !init_q)
    (take && vec_addr == VEC_FAST) |-> !$past(status_word[0]));

  // R7
  norm_masked_chk: assert property (@(posedge clk) disable iff (rst || !init_q)
    (take && vec_addr == VEC_NORM) |-> !$past(status_word[1]));

  // R6
  fast_flag_kept_chk: assert property (@(posedge clk) disable iff (rst || !init_q)
    (take && vec_addr != VEC_FAST && vec_addr != VEC_BASE)
      |-> status_word[0] == $past(status_word[0]));

  // R9
  user_flags_frozen_chk: assert property (@(posedge clk) disable iff (rst || !init_q)
    ($past(status_word[4:2]) == 3'd0 && !take && !$past(exc_ret))
      |-> status_word[1:0] == $past(status_word[1:0]));
endmodule

// File: tb/sim_exc_vector_unit.sv
module sim_exc_vector_unit;
  localparam int AW = 32;

  typedef struct packed {
    logic [AW-1:0] vec;
    logic [4:0]    saved;
    logic [AW-1:0] link;
    logic [4:0]    stat;
  } exp_t;

  // request bit order {reset, dabt, fast, norm, pabt, trap, undef}
  localparam logic [6:0] Q_RST = 7'b1000000, Q_DAB = 7'b0100000, Q_FST = 7'b0010000,
                         Q_NRM = 7'b0001000, Q_PAB = 7'b0000100, Q_TRP = 7'b0000010,
                         Q_UND = 7'b0000001;
  localparam logic [2:0] USR = 3'd0, FST = 3'd1, NRM = 3'd2, SUP = 3'd3, ABT = 3'd4, UND = 3'd5;

  logic clk = 1'b0, rst = 1'b1;
  logic [6:0] reqs = '0;
  logic [AW-1:0] ret_addr = '0;
  logic vec_ack = 0, exc_ret = 0, flag_wr = 0, flag_wr_i = 0, flag_wr_f = 0;
  logic [4:0] ret_status = '0;
  logic take, save_stat_we, save_link_we;
  logic [AW-1:0] vec_addr, save_link_val;
  logic [4:0] status_word, save_stat_val;

  int checks = 0, fails = 0, takes = 0;
  exp_t sb[$];
  bit done = 0;

  always #4 clk = ~clk;

  exc_vector_unit #(.AW(AW), .VEC_BASE('0)) u0 (
    .clk(clk), .rst(rst),
    .req_reset(reqs[6]), .req_dabt(reqs[5]), .req_fast(reqs[4]), .req_norm(reqs[3]),
    .req_pabt(reqs[2]), .req_trap(reqs[1]), .req_undef(reqs[0]),
    .ret_addr(ret_addr), .vec_ack(vec_ack), .exc_ret(exc_ret), .ret_status(ret_status),
    .flag_wr(flag_wr), .flag_wr_i(flag_wr_i), .flag_wr_f(flag_wr_f),
    .take(take), .vec_addr(vec_addr), .status_word(status_word),
    .save_stat_we(save_stat_we), .save_stat_val(save_stat_val),
    .save_link_we(save_link_we), .save_link_val(save_link_val)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every take
  always @(posedge clk) begin
    #1;
    if (!rst && take) begin
      takes++;
      if (sb.size() == 0) begin
        chk(1, 0, "R11 unexpected take");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(vec_addr, e.vec, "R1/R2 vector");
        chk(save_stat_val, e.saved, "R4 saved status");
        chk(save_link_val, e.link, "R4 saved link");
        chk({save_stat_we, save_link_we}, 2'b11, "R4 strobes");
        chk(status_word, e.stat, "R3/R5/R6 status after entry");
      end
    end
  end

  task automatic do_ret(input logic [4:0] v);
    @(negedge clk); exc_ret = 1; ret_status = v;
    @(negedge clk); exc_ret = 0;
  endtask

  // drive one request pattern, expect one take, provoke ignored requests while busy
  task automatic run_exc(input logic [6:0] r, input logic [AW-1:0] link,
                         input logic [AW-1:0] ev, input logic [4:0] esaved,
                         input logic [4:0] estat, input string tag);
    int t0;
    exp_t e;
    e.vec = ev; e.saved = esaved; e.link = link; e.stat = estat;
    sb.push_back(e);
    t0 = takes;
    @(negedge clk); reqs = r; ret_addr = link;
    @(negedge clk); reqs = Q_DAB | Q_TRP;   // ignored while waiting for ack (R11)
    @(negedge clk);
    @(negedge clk); reqs = '0; vec_ack = 1;
    @(negedge clk); vec_ack = 0;
    chk(takes - t0, 1, {"R10/R11 one take for ", tag});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13
    chk(status_word, {SUP, 2'b11}, "R13 status after reset");
    chk(take, 0, "R13 take low after reset");

    // R9 privileged write
    flag_wr = 1; flag_wr_i = 0; flag_wr_f = 0;
    @(negedge clk); flag_wr = 0;
    chk(status_word, {SUP, 2'b00}, "R9 privileged write");

    // R8 return
    do_ret({USR, 2'b00});
    chk(status_word, {USR, 2'b00}, "R8 return restores");

    // R9 user write ignored
    @(negedge clk); flag_wr = 1; flag_wr_i = 1; flag_wr_f = 1;
    @(negedge clk); flag_wr = 0;
    chk(status_word, {USR, 2'b00}, "R9 user write ignored");

    // R1 all at once: reset wins, sets both masks (R6)
    run_exc(7'h7F, 32'h100, 32'h00, {USR, 2'b00}, {SUP, 2'b11}, "reset");
    do_ret({USR, 2'b00});
    run_exc(7'h3F, 32'h104, 32'h10, {USR, 2'b00}, {ABT, 2'b10}, "dabt");
    do_ret({USR, 2'b00});
    run_exc(Q_FST | Q_NRM | Q_PAB, 32'h108, 32'h1C, {USR, 2'b00}, {FST, 2'b11}, "fast");
    do_ret({USR, 2'b00});
    run_exc(Q_NRM | Q_PAB | Q_TRP, 32'h10C, 32'h18, {USR, 2'b00}, {NRM, 2'b10}, "norm");
    do_ret({USR, 2'b00});
    run_exc(Q_PAB | Q_TRP | Q_UND, 32'h110, 32'h0C, {USR, 2'b00}, {ABT, 2'b10}, "pabt");
    do_ret({USR, 2'b00});
    // R1 tie: undef beats trap
    run_exc(Q_TRP | Q_UND, 32'h114, 32'h04, {USR, 2'b00}, {UND, 2'b10}, "undef tie");
    do_ret({USR, 2'b00});
    run_exc(Q_TRP, 32'h118, 32'h08, {USR, 2'b00}, {SUP, 2'b10}, "trap");

    // R7 masking
    do_ret({USR, 2'b10});
    run_exc(Q_NRM | Q_PAB, 32'h11C, 32'h0C, {USR, 2'b10}, {ABT, 2'b10}, "norm masked");
    do_ret({USR, 2'b01});
    run_exc(Q_FST | Q_NRM, 32'h120, 32'h18, {USR, 2'b01}, {NRM, 2'b11}, "fast masked");
    do_ret({USR, 2'b11});
    begin
      int t0;
      t0 = takes;
      @(negedge clk); reqs = Q_FST | Q_NRM;
      repeat (3) @(negedge clk);
      reqs = '0;
      @(negedge clk);
      chk(takes - t0, 0, "R7 both interrupts masked, no take");
      chk(status_word, {USR, 2'b11}, "R7 status unchanged when masked");
    end
    run_exc(Q_RST, 32'h124, 32'h00, {USR, 2'b11}, {SUP, 2'b11}, "reset unmasked R7");

    // R12 entry with return in same cycle
    do_ret({USR, 2'b00});
    begin
      exp_t e;
      e.vec = 32'h08; e.saved = {USR, 2'b00}; e.link = 32'h200; e.stat = {SUP, 2'b10};
      sb.push_back(e);
      @(negedge clk); reqs = Q_TRP; ret_addr = 32'h200; exc_ret = 1; ret_status = {NRM, 2'b11};
      @(negedge clk); reqs = '0; exc_ret = 0;
      chk(status_word, {SUP, 2'b10}, "R12 return dropped on entry");
      @(negedge clk); vec_ack = 1;
      @(negedge clk); vec_ack = 0;
    end
    // R12 entry with privileged flag write in same cycle
    do_ret({SUP, 2'b00});
    begin
      exp_t e;
      e.vec = 32'h04; e.saved = {SUP, 2'b00}; e.link = 32'h204; e.stat = {UND, 2'b10};
      sb.push_back(e);
      @(negedge clk); reqs = Q_UND; ret_addr = 32'h204; flag_wr = 1; flag_wr_i = 0; flag_wr_f = 1;
      @(negedge clk); reqs = '0; flag_wr = 0;
      chk(status_word, {UND, 2'b10}, "R12 write dropped on entry");
      @(negedge clk); vec_ack = 1;
      @(negedge clk); vec_ack = 0;
    end
    repeat (2) @(negedge clk);
    chk(sb.size(), 0, "R10 all expected takes seen");
    done = 1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule